// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that moves data by walking a list of descriptors kept in memory. Each descriptor is four 32-bit words: a link word, a source address, a target address and a command word. The channel reads the four words, moves the data that the command word describes, and then follows the link word to the next descriptor. It stops when the link word carries its stop flag, or when software clears the run bit. A chain whose last link points back to its first descriptor keeps running until software stops it.

Software programs the channel through a small word-addressed register port. Register 0 is control/status, register 1 is the descriptor pointer, and registers 2, 3 and 4 are the current source, target and command. Data moves through a single-outstanding request/response memory port, one word read and one word write per element. A peripheral can pace the transfer by raising a request line. The channel grants one burst for each request and answers each burst with a one-cycle acknowledge.

Top module: `chain_dma_channel`

## Requirements
- R1: After reset the channel is stopped: register 0 reads 0x0000_0008, `irq` is low and `mem_req` is low.
- R2: Descriptor fetch reads four words at the pointer with bits 3:0 forced to zero, at offsets 0, 4, 8 and 12. The words are, in order: link, source, target, command. Bits 3:0 written to the pointer register do not move the fetch.
- R3: Each element reads the word at the source address and writes it to the target address. Command bit 31 advances the source address by the element width after each element and bit 30 advances the target address the same way; an address whose bit is clear stays fixed.
- R4: Command bits 15:14 set the element width: 1 gives 1 byte, 2 gives 2 bytes, 3 or 0 gives 4 bytes. Bits 12:0 hold the byte length. A transfer of length L and width W makes ceil(L/W) elements, so each advancing address ends at its start plus ceil(L/W)*W.
- R5: If command bit 29 (source paced) or bit 28 (target paced) is set, no data access starts until `per_req` is high, and this holds before every burst. Command bits 17:16 set the burst size: 2 gives 16 bytes, 3 gives 32 bytes, 1 or 0 gives 8 bytes. The last burst of a descriptor may be shorter. A paced transfer pulses `per_ack` for one cycle after each burst. Register 0 bit 8 shows `per_req`.
- R6: Link bit 0 ends the chain after the current descriptor. The channel then clears run (register 0 bit 31) and sets stop state (bit 3).
- R7: If run is cleared while data is moving, the channel stops only at the end of a burst or between descriptors. A cyclic chain therefore stops with a whole number of bursts done.
- R8: Command bit 22 sets status bit 1 when the descriptor's data phase begins. Command bit 21 sets status bit 2 when the descriptor finishes. Writing 1 to a status bit in register 0 clears it. `irq` is the OR of status bits 2:0 together with (bit 29 and stopped).
- R9: A descriptor with length 0 makes no data access and goes straight on to link processing.
- R10: With register 0 bit 30 set, starting the channel uses the source, target and command registers as software wrote them. No descriptor is fetched, and the channel stops after that one transfer.
- R11: A memory response with `mem_err` set sets status bit 0, clears run and stops the channel. No write follows a failed read.
- R12: Writes to registers 1 to 4 are ignored while the channel is not stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory request, held until response |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory read data |
| mem_err | input | 1 | Memory response is an error |
| per_req | input | 1 | Peripheral pacing request |
| per_ack | output | 1 | One-cycle burst acknowledge |

## Verification
The bench goes after these corner cases:
- A pointer written with junk in its low bits. A design that does not mask them fetches shifted words and copies the wrong data.
- Lengths that are not a multiple of the element width. Wrong rounding shows up as an extra or missing write, or as a wrong final address.
- A zero-length descriptor followed by a real one. A design that mishandles it writes when it should not.
- Clearing run in a cyclic chain. An odd write count means the channel stopped inside a burst.
- A paced transfer held off by a low request. Any data read during the hold, a miscounted acknowledge, or an address register overwritten during the run is caught at the ports.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int WORD_W = 32;

  // command word field positions
  localparam int C_SRC_INC = 31;
  localparam int C_TGT_INC = 30;
  localparam int C_SRC_PACE = 29;
  localparam int C_TGT_PACE = 28;
  localparam int C_START_IE = 22;
  localparam int C_END_IE = 21;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_PACE, ST_RD, ST_WR, ST_NEXT
  } cdma_state_e;

  function automatic logic [5:0] elem_bytes(input logic [1:0] code);
    case (code)
      2'd1:    elem_bytes = 6'd1;
      2'd2:    elem_bytes = 6'd2;
      default: elem_bytes = 6'd4;
    endcase
  endfunction

  function automatic logic [6:0] burst_bytes(input logic [1:0] code);
    case (code)
      2'd2:    burst_bytes = 7'd16;
      2'd3:    burst_bytes = 7'd32;
      default: burst_bytes = 7'd8;
    endcase
  endfunction
endpackage

// File: rtl/cdma_engine.sv
module cdma_engine
  import cdma_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              nodesc,
  input  logic              ld_ptr,
  input  logic              ld_src,
  input  logic              ld_tgt,
  input  logic              ld_cmd,
  input  logic [WORD_W-1:0] ld_data,
  output logic [WORD_W-1:0] cur_ptr,
  output logic [WORD_W-1:0] cur_src,
  output logic [WORD_W-1:0] cur_tgt,
  output logic [WORD_W-1:0] cur_cmd,
  output logic              stopped,
  output logic              ev_start,
  output logic              ev_end,
  output logic              ev_err,
  output logic              clr_run,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err,
  input  logic              per_req,
  output logic              per_ack
);
  localparam int BC_W = 7;

  cdma_state_e       state_q, state_d;
  logic [WORD_W-1:0] src_q, src_d, tgt_q, tgt_d, cmd_q, cmd_d;
  logic [WORD_W-1:0] nxt_q, nxt_d, ptr_q, ptr_d, buf_q, buf_d;
  logic [LEN_W-1:0]  rem_q, rem_d, elem, step;
  logic [BC_W-1:0]   bcnt_q, bcnt_d, bnext;
  logic [1:0]        widx_q, widx_d;
  logic              ack_q, ack_d, flow, burst_end;

  assign flow      = cmd_q[C_SRC_PACE] | cmd_q[C_TGT_PACE];
  assign elem      = LEN_W'(elem_bytes(cmd_q[15:14]));
  assign step      = (rem_q < elem) ? rem_q : elem;
  assign bnext     = bcnt_q + BC_W'(step);
  assign burst_end = (rem_q == step) || (bnext >= burst_bytes(cmd_q[17:16]));

  always_comb begin
    state_d = state_q; src_d = src_q; tgt_d = tgt_q; cmd_d = cmd_q;
    nxt_d = nxt_q; ptr_d = ptr_q; buf_d = buf_q; rem_d = rem_q;
    bcnt_d = bcnt_q; widx_d = widx_q; ack_d = 1'b0;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = buf_q;
    ev_start = 1'b0; ev_end = 1'b0; ev_err = 1'b0; clr_run = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ld_ptr) ptr_d = ld_data;
        if (ld_src) src_d = ld_data;
        if (ld_tgt) tgt_d = ld_data;
        if (ld_cmd) cmd_d = ld_data;
        if (run) begin
          if (nodesc) begin
            rem_d    = cmd_q[LEN_W-1:0];
            bcnt_d   = '0;
            ev_start = cmd_q[C_START_IE];
            state_d  = ST_PACE;
          end else begin
            widx_d  = 2'd0;
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = {ptr_q[WORD_W-1:4], 4'b0000} + {{(WORD_W-4){1'b0}}, widx_q, 2'b00};
        if (mem_rvalid && mem_err) begin
          ev_err = 1'b1; clr_run = 1'b1; state_d = ST_IDLE;
        end else if (mem_rvalid) begin
          widx_d = widx_q + 2'd1;
          case (widx_q)
            2'd0: nxt_d = mem_rdata;
            2'd1: src_d = mem_rdata;
            2'd2: tgt_d = mem_rdata;
            default: begin
              cmd_d    = mem_rdata;
              rem_d    = mem_rdata[LEN_W-1:0];
              bcnt_d   = '0;
              ev_start = mem_rdata[C_START_IE];
              state_d  = ST_PACE;
            end
          endcase
        end
      end
      ST_PACE: begin
        if (rem_q == '0) state_d = ST_NEXT;
        else if (!run) state_d = ST_IDLE;
        else if (!flow || per_req) state_d = ST_RD;
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = src_q;
        if (mem_rvalid && mem_err) begin
          ev_err = 1'b1; clr_run = 1'b1; state_d = ST_IDLE;
        end else if (mem_rvalid) begin
          buf_d   = mem_rdata;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = tgt_q;
        if (mem_rvalid && mem_err) begin
          ev_err = 1'b1; clr_run = 1'b1; state_d = ST_IDLE;
        end else if (mem_rvalid) begin
          if (cmd_q[C_SRC_INC]) src_d = src_q + WORD_W'(elem);
          if (cmd_q[C_TGT_INC]) tgt_d = tgt_q + WORD_W'(elem);
          rem_d = rem_q - step;
          if (burst_end) begin
            bcnt_d  = '0;
            ack_d   = flow;
            state_d = ST_PACE;
          end else begin
            bcnt_d  = bnext;
            state_d = ST_RD;
          end
        end
      end
      ST_NEXT: begin
        ev_end = cmd_q[C_END_IE];
        if (nodesc || nxt_q[0] || !run) begin
          clr_run = 1'b1;
          state_d = ST_IDLE;
        end else begin
          ptr_d   = nxt_q;
          widx_d  = 2'd0;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q <= '0; tgt_q <= '0; cmd_q <= '0; nxt_q <= '0; ptr_q <= '0; buf_q <= '0;
      rem_q <= '0; bcnt_q <= '0; widx_q <= '0; ack_q <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q <= src_d; tgt_q <= tgt_d; cmd_q <= cmd_d; nxt_q <= nxt_d;
      ptr_q <= ptr_d; buf_q <= buf_d;
      rem_q <= rem_d; bcnt_q <= bcnt_d; widx_q <= widx_d; ack_q <= ack_d;
    end
  end

  assign cur_ptr = ptr_q;
  assign cur_src = src_q;
  assign cur_tgt = tgt_q;
  assign cur_cmd = cmd_q;
  assign stopped = (state_q == ST_IDLE);
  assign per_ack = ack_q;

  // R2: a pending request keeps its address until answered
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
  // R1: a stopped channel makes no memory or peripheral traffic
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!mem_req && !per_ack));
  // R5: acknowledge is a single-cycle pulse
  a_r5_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);
  // R5: a paced burst waits for the peripheral request
  a_r5_paced_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PACE && flow && !per_req) |=> (state_q != ST_RD));
  // R9: no data read is issued with nothing left to move
  a_r9_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD) |-> (rem_q != '0));
  // R4: each completed element shrinks the remaining length
  a_r4_rem_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR && mem_rvalid && !mem_err) |=> (rem_q < $past(rem_q)));
endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              per_req,
  input  logic              stopped,
  input  logic              ev_start,
  input  logic              ev_end,
  input  logic              ev_err,
  input  logic              clr_run,
  input  logic [WORD_W-1:0] cur_ptr,
  input  logic [WORD_W-1:0] cur_src,
  input  logic [WORD_W-1:0] cur_tgt,
  input  logic [WORD_W-1:0] cur_cmd,
  output logic              run,
  output logic              nodesc,
  output logic              ld_ptr,
  output logic              ld_src,
  output logic              ld_tgt,
  output logic              ld_cmd
);
  logic       run_q, run_d, nod_q, nod_d, sten_q, sten_d, wr_ctrl;
  logic [2:0] st_q, st_d, w1c;

  assign wr_ctrl = reg_wr && (reg_addr == 3'd0);
  assign w1c     = wr_ctrl ? reg_wdata[2:0] : 3'b000;

  always_comb begin
    run_d = run_q; nod_d = nod_q; sten_d = sten_q;
    if (wr_ctrl) begin
      run_d  = reg_wdata[31];
      nod_d  = reg_wdata[30];
      sten_d = reg_wdata[29];
    end else if (clr_run) begin
      run_d = 1'b0;
    end
    st_d = (st_q & ~w1c) | {ev_end, ev_start, ev_err};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; nod_q <= 1'b0; sten_q <= 1'b0; st_q <= 3'b000;
    end else begin
      run_q <= run_d; nod_q <= nod_d; sten_q <= sten_d; st_q <= st_d;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {run_q, nod_q, sten_q, 20'b0, per_req, 4'b0, stopped, st_q};
      3'd1:    reg_rdata = cur_ptr;
      3'd2:    reg_rdata = cur_src;
      3'd3:    reg_rdata = cur_tgt;
      3'd4:    reg_rdata = cur_cmd;
      default: reg_rdata = '0;
    endcase
  end

  assign run    = run_q;
  assign nodesc = nod_q;
  assign ld_ptr = reg_wr && (reg_addr == 3'd1);
  assign ld_src = reg_wr && (reg_addr == 3'd2);
  assign ld_tgt = reg_wr && (reg_addr == 3'd3);
  assign ld_cmd = reg_wr && (reg_addr == 3'd4);
  assign irq    = (|st_q) || (sten_q && stopped);

  // R8: a write of 1 clears the start status unless a new event arrives
  a_r8_w1c_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[1] && !ev_start) |=> !st_q[1]);
  // R6: a hardware stop request drops run
  a_r6_run_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_run && !wr_ctrl) |=> !run_q);
endmodule

// File: rtl/chain_dma_channel.sv
module chain_dma_channel
  import cdma_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  input  logic        per_req,
  output logic        per_ack
);
  logic run, nodesc, ld_ptr, ld_src, ld_tgt, ld_cmd;
  logic stopped, ev_start, ev_end, ev_err, clr_run;
  logic [WORD_W-1:0] cur_ptr, cur_src, cur_tgt, cur_cmd;

  cdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .per_req(per_req),
    .stopped(stopped), .ev_start(ev_start), .ev_end(ev_end), .ev_err(ev_err),
    .clr_run(clr_run), .cur_ptr(cur_ptr), .cur_src(cur_src), .cur_tgt(cur_tgt),
    .cur_cmd(cur_cmd), .run(run), .nodesc(nodesc), .ld_ptr(ld_ptr),
    .ld_src(ld_src), .ld_tgt(ld_tgt), .ld_cmd(ld_cmd)
  );

  cdma_engine #(.LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .nodesc(nodesc), .ld_ptr(ld_ptr),
    .ld_src(ld_src), .ld_tgt(ld_tgt), .ld_cmd(ld_cmd), .ld_data(reg_wdata),
    .cur_ptr(cur_ptr), .cur_src(cur_src), .cur_tgt(cur_tgt), .cur_cmd(cur_cmd),
    .stopped(stopped), .ev_start(ev_start), .ev_end(ev_end), .ev_err(ev_err),
    .clr_run(clr_run), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .per_req(per_req), .per_ack(per_ack)
  );
endmodule

// File: tb/chain_dma_channel_test.sv
`timescale 1ns/1ps
module chain_dma_channel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, mem_req, mem_we, mem_rvalid, mem_err, per_req, per_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];
  logic [31:0] err_addr;
  int rd_cnt, wr_cnt, ack_cnt;
  int checks, fails;

  localparam logic [31:0] RUN = 32'h8000_0000, NODESC = 32'h4000_0000, STOPEN = 32'h2000_0000;

  always #2 clk = ~clk;

  chain_dma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .per_req(per_req), .per_ack(per_ack)
  );

  // memory with one-cycle response
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_err    <= 1'b0;
    if (rst_n && mem_req && !mem_rvalid) begin
      mem_rvalid <= 1'b1;
      if (mem_addr == err_addr) mem_err <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[11:2]] = mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
        rd_cnt = rd_cnt + 1;
      end
    end
    if (rst_n && per_ack) ack_cnt = ack_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_stop(input string req);
    logic [31:0] v;
    bit done = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4000 && !done; i++) begin
      rd_reg(3'd0, v);
      done = v[3];
    end
    check(done, req, 0, 1);
  endtask

  function automatic logic [31:0] mk_cmd(input bit si, input bit ti, input bit fs, input bit ft,
      input bit sie, input bit eie, input logic [1:0] burst, input logic [1:0] wid,
      input logic [12:0] len);
    mk_cmd = {si, ti, fs, ft, 5'b0, sie, eie, 2'b0, 1'b0, burst, wid, 1'b0, len};
  endfunction

  function automatic int wbytes(input logic [1:0] c);
    wbytes = (c == 2'd1) ? 1 : (c == 2'd2) ? 2 : 4;
  endfunction

  function automatic int n_elem(input int len, input logic [1:0] c);
    n_elem = (len + wbytes(c) - 1) / wbytes(c);
  endfunction

  task automatic put_desc(input int a, input logic [31:0] nx, input logic [31:0] s,
                          input logic [31:0] t, input logic [31:0] c);
    mem[a/4] = nx; mem[a/4+1] = s; mem[a/4+2] = t; mem[a/4+3] = c;
  endtask

  logic [31:0] v;
  int r0, w0, a0, bad;

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    err_addr = 32'hFFFF_FFFF;
    rd_cnt = 0; wr_cnt = 0; ack_cnt = 0; checks = 0; fails = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0; per_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_reg(3'd0, v);
    check(v == 32'h8, "R1 ctrl", v, 32'h8);
    check(!irq && !mem_req, "R1 irq/req", {irq, mem_req}, 0);

    // R2, R3: copy 64 bytes, pointer written with junk low bits
    put_desc(32'h40, 32'h1, 32'h400, 32'h800, mk_cmd(1,1,0,0,0,0,2'd3,2'd3,13'd64));
    wr_reg(3'd1, 32'h4F);
    wr_reg(3'd0, RUN);
    wait_stop("R2 stop");
    bad = 0;
    for (int i = 0; i < 16; i++) if (mem[32'h800/4 + i] != mem[32'h400/4 + i]) bad++;
    check(bad == 0, "R2 R3 data copied", bad, 0);
    rd_reg(3'd2, v); check(v == 32'h440, "R3 final src", v, 32'h440);
    rd_reg(3'd3, v); check(v == 32'h840, "R3 final tgt", v, 32'h840);
    // R6: chain end clears run, sets stop state
    rd_reg(3'd0, v); check(v[31] == 0 && v[3] == 1, "R6 run/stop", v, 32'h8);

    // R4, R3: random widths, lengths and increments
    for (int k = 0; k < 8; k++) begin
      logic [1:0] wc; int len; bit si, ti; int n;
      wc = 2'($urandom_range(0, 3)); len = $urandom_range(1, 40);
      si = 1'($urandom_range(0, 1)); ti = 1'($urandom_range(0, 1));
      n = n_elem(len, wc);
      put_desc(32'h80, 32'h1, 32'h400, 32'h900, mk_cmd(si,ti,0,0,0,0,2'd1,wc,13'(len)));
      w0 = wr_cnt;
      wr_reg(3'd1, 32'h80);
      wr_reg(3'd0, RUN);
      wait_stop("R4 stop");
      check(wr_cnt - w0 == n, "R4 element count", wr_cnt - w0, n);
      rd_reg(3'd2, v); check(v == 32'h400 + (si ? n * wbytes(wc) : 0), "R3 R4 src end", v, 32'h400 + (si ? n * wbytes(wc) : 0));
      rd_reg(3'd3, v); check(v == 32'h900 + (ti ? n * wbytes(wc) : 0), "R3 R4 tgt end", v, 32'h900 + (ti ? n * wbytes(wc) : 0));
    end

    // R5, R12: target paced, 8-byte bursts, held off by low request
    put_desc(32'hC0, 32'h1, 32'h400, 32'hA00, mk_cmd(1,0,0,1,0,0,2'd1,2'd3,13'd24));
    r0 = rd_cnt; a0 = ack_cnt;
    wr_reg(3'd1, 32'hC0);
    wr_reg(3'd0, RUN);
    repeat (30) @(negedge clk);
    check(rd_cnt - r0 == 4, "R5 no data before request", rd_cnt - r0, 4);
    rd_reg(3'd0, v); check(v[8] == 0, "R5 pending bit low", v[8], 0);
    wr_reg(3'd2, 32'h123);
    per_req = 1'b1;
    rd_reg(3'd0, v); check(v[8] == 1, "R5 pending bit high", v[8], 1);
    wait_stop("R5 stop");
    per_req = 1'b0;
    check(ack_cnt - a0 == 3, "R5 one ack per burst", ack_cnt - a0, 3);
    rd_reg(3'd2, v); check(v == 32'h418, "R12 src write ignored", v, 32'h418);
    rd_reg(3'd3, v); check(v == 32'hA00, "R3 fixed tgt", v, 32'hA00);

    // R9: zero-length descriptor then a real one
    put_desc(32'h00, 32'h20, 32'h400, 32'hB00, mk_cmd(1,1,0,0,0,0,2'd1,2'd3,13'd0));
    put_desc(32'h20, 32'h1, 32'h400, 32'hB00, mk_cmd(1,1,0,0,0,0,2'd1,2'd3,13'd8));
    r0 = rd_cnt; w0 = wr_cnt;
    wr_reg(3'd1, 32'h00);
    wr_reg(3'd0, RUN);
    wait_stop("R9 stop");
    check(wr_cnt - w0 == 2, "R9 writes", wr_cnt - w0, 2);
    check(rd_cnt - r0 == 10, "R9 reads", rd_cnt - r0, 10);

    // R8: interrupts and write-1-to-clear
    put_desc(32'h60, 32'h1, 32'h400, 32'hB00, mk_cmd(1,1,0,0,1,1,2'd1,2'd3,13'd4));
    wr_reg(3'd1, 32'h60);
    wr_reg(3'd0, RUN);
    wait_stop("R8 stop");
    rd_reg(3'd0, v); check(v[2:0] == 3'b110 && irq, "R8 status set", {irq, v[2:0]}, 4'b1110);
    wr_reg(3'd0, 32'h2);
    rd_reg(3'd0, v); check(v[2:0] == 3'b100 && irq, "R8 start cleared", {irq, v[2:0]}, 4'b1100);
    wr_reg(3'd0, 32'h4);
    #1 check(!irq, "R8 irq low", irq, 0);
    wr_reg(3'd0, STOPEN);
    #1 check(irq, "R8 stop irq", irq, 1);
    wr_reg(3'd0, 32'h0);

    // R7: cyclic chain stopped by clearing run
    put_desc(32'h00, 32'h20, 32'h400, 32'hC00, mk_cmd(1,1,0,0,0,0,2'd1,2'd3,13'd8));
    put_desc(32'h20, 32'h00, 32'h410, 32'hC10, mk_cmd(1,1,0,0,0,0,2'd1,2'd3,13'd8));
    w0 = wr_cnt;
    wr_reg(3'd1, 32'h00);
    wr_reg(3'd0, RUN);
    for (int i = 0; i < 2000 && (wr_cnt - w0) < 9; i++) @(negedge clk);
    wr_reg(3'd0, 32'h0);
    wait_stop("R7 stop");
    check((wr_cnt - w0) % 2 == 0 && (wr_cnt - w0) >= 9, "R7 whole bursts, looped", wr_cnt - w0, 10);

    // R10: no-descriptor mode
    wr_reg(3'd2, 32'h400);
    wr_reg(3'd3, 32'hD00);
    wr_reg(3'd4, mk_cmd(1,1,0,0,0,0,2'd1,2'd3,13'd8));
    r0 = rd_cnt; w0 = wr_cnt;
    wr_reg(3'd0, RUN | NODESC);
    wait_stop("R10 stop");
    check(rd_cnt - r0 == 2 && wr_cnt - w0 == 2, "R10 no fetch", rd_cnt - r0, 2);
    check(mem[32'hD00/4] == mem[32'h400/4] && mem[32'hD04/4] == mem[32'h404/4], "R10 data", mem[32'hD00/4], mem[32'h400/4]);
    wr_reg(3'd0, 32'h0);

    // R11: bus error on source read
    put_desc(32'h60, 32'h1, 32'h500, 32'hE00, mk_cmd(1,1,0,0,0,0,2'd1,2'd3,13'd8));
    err_addr = 32'h500;
    w0 = wr_cnt;
    wr_reg(3'd1, 32'h60);
    wr_reg(3'd0, RUN);
    wait_stop("R11 stop");
    rd_reg(3'd0, v);
    check(v[0] == 1 && v[31] == 0 && irq, "R11 error status", v, 32'h9);
    check(wr_cnt == w0, "R11 no write", wr_cnt - w0, 0);
    err_addr = 32'hFFFF_FFFF;
    wr_reg(3'd0, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule